// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Indirect and Interrupt Cycles

This block is the control sequencer of a small multicycle processor. It owns four registers: the program counter (PC), the instruction register (IR), the memory address register (MAR) and the memory buffer register (MBR). It also owns an interrupt-enable flag. The block drives a single memory port. That port carries an address, write data, separate read and write strobes, and a ready handshake. Each instruction goes through a fetch cycle and, when the instruction word asks for it, an indirect-address cycle. Control then passes to an external execute unit through a request/done handshake. When execution finishes, the sequencer checks for an interrupt. If the enable flag is set and a request is pending, it saves the return PC at a fixed memory location and redirects the PC to the handler.

The states are:
- `ST_FETCH_ADDR`: MAR takes PC.
- `ST_FETCH_RD`: read memory into MBR and advance PC.
- `ST_FETCH_IR`: IR takes MBR.
- `ST_IND_CHK`: test the indirect bit. If it is set, MAR takes the address field of MBR.
- `ST_IND_RD`: read the operand address into MBR.
- `ST_EXEC`: hold the execute request until done.
- `ST_INT_SAVE`: MBR takes PC and MAR takes the save address. The enable flag is cleared and the request is acknowledged.
- `ST_INT_WR`: write MBR to memory.
- `ST_INT_JMP`: PC takes the handler address.

The transitions are:
- `ST_FETCH_ADDR` to `ST_FETCH_RD` to `ST_FETCH_IR` to `ST_IND_CHK`.
- `ST_IND_CHK` goes to `ST_IND_RD` when the indirect bit is set, otherwise to `ST_EXEC`.
- `ST_IND_RD` goes to `ST_EXEC` on ready.
- `ST_EXEC` goes to `ST_INT_SAVE` on done when the flag is enabled and a request is pending, otherwise to `ST_FETCH_ADDR`.
- `ST_INT_SAVE` to `ST_INT_WR` to `ST_INT_JMP` to `ST_FETCH_ADDR`.

The memory states wait until ready.

Top module: `instr_cycle_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, PC equals `START_ADDR` and no memory request or acknowledge is driven. Interrupts are disabled out of reset.
- R2: A fetch reads memory at the current PC. The returned word becomes the instruction output, and PC advances by one, before execute is requested.
- R3: Once a read or write request is raised, request, address and write data stay unchanged until the cycle in which ready is seen.
- R4: When bit `IND_BIT` (default 15) of the instruction is 1, a second read is issued at the instruction's low `ADDR_W` bits (default 12). The low `ADDR_W` bits of the returned word are presented as the operand address.
- R5: When that bit is 0, no second read occurs and the operand address is the instruction's own low `ADDR_W` bits.
- R6: The execute request stays high until execute-done is seen. No memory request is driven while it is high.
- R7: When execute is done and the interrupt flag is clear, or no request is pending, the next fetch begins at the incremented PC.
- R8: When execute is done, the flag is set and a request is pending, the sequencer writes the incremented PC, zero-extended, to address `SAVE_ADDR`.
- R9: After that write, the next fetch reads from `HANDLER_ADDR`.
- R10: Entry to the interrupt cycle produces a one-cycle acknowledge pulse and clears the flag. A still-pending request is not taken again until the enable-set input is pulsed.
- R11: Read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | ADDR_W | Memory address (MAR) |
| mem_wdata | output | DATA_W | Memory write data (MBR) |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_rdata | input | DATA_W | Memory read data |
| mem_ready | input | 1 | Memory access completes this cycle |
| exec_req | output | 1 | Execute stage requested |
| exec_done | input | 1 | Execute stage finished |
| instr | output | DATA_W | Instruction register |
| operand_addr | output | ADDR_W | Effective operand address |
| pc_out | output | ADDR_W | Program counter |
| irq_req | input | 1 | Interrupt request, level |
| irq_ack | output | 1 | Interrupt accepted pulse |
| ie_set | input | 1 | Re-enable interrupts |

## Verification
The assertions rely on two properties of the environment. The memory must raise ready only while a request is present, and must eventually raise it. Execute-done must be raised only while execute is requested. The bench memory model answers only an active strobe, with a latency of zero to two cycles that rotates per access. It drops ready after one cycle. The execute model pulses done once per request. The enable-set pulse is issued only between instructions.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [3:0] {
        ST_FETCH_ADDR,
        ST_FETCH_RD,
        ST_FETCH_IR,
        ST_IND_CHK,
        ST_IND_RD,
        ST_EXEC,
        ST_INT_SAVE,
        ST_INT_WR,
        ST_INT_JMP
    } seq_state_e;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_mbr;
        logic mar_from_save;
        logic mbr_from_mem;
        logic mbr_from_pc;
        logic ir_from_mbr;
        logic pc_inc;
        logic pc_from_hdl;
        logic ie_clr;
    } seq_ctl_t;

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     mem_ready,
    input  logic     exec_done,
    input  logic     irq_req,
    input  logic     ie,
    input  logic     ir_ind,
    output seq_ctl_t ctl,
    output logic     mem_rd,
    output logic     mem_wr,
    output logic     exec_req,
    output logic     irq_ack
);

    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH_ADDR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        ctl      = '0;
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        exec_req = 1'b0;
        irq_ack  = 1'b0;
        unique case (state_q)
            ST_FETCH_ADDR: begin
                ctl.mar_from_pc = 1'b1;
                state_d = ST_FETCH_RD;
            end
            ST_FETCH_RD: begin
                mem_rd = 1'b1;
                if (mem_ready) begin
                    ctl.mbr_from_mem = 1'b1;
                    ctl.pc_inc       = 1'b1;
                    state_d          = ST_FETCH_IR;
                end
            end
            ST_FETCH_IR: begin
                ctl.ir_from_mbr = 1'b1;
                state_d = ST_IND_CHK;
            end
            ST_IND_CHK: begin
                if (ir_ind) begin
                    ctl.mar_from_mbr = 1'b1;
                    state_d = ST_IND_RD;
                end else begin
                    state_d = ST_EXEC;
                end
            end
            ST_IND_RD: begin
                mem_rd = 1'b1;
                if (mem_ready) begin
                    ctl.mbr_from_mem = 1'b1;
                    state_d = ST_EXEC;
                end
            end
            ST_EXEC: begin
                exec_req = 1'b1;
                if (exec_done)
                    state_d = (ie && irq_req) ? ST_INT_SAVE : ST_FETCH_ADDR;
            end
            ST_INT_SAVE: begin
                ctl.mbr_from_pc   = 1'b1;
                ctl.mar_from_save = 1'b1;
                ctl.ie_clr        = 1'b1;
                irq_ack           = 1'b1;
                state_d           = ST_INT_WR;
            end
            ST_INT_WR: begin
                mem_wr = 1'b1;
                if (mem_ready) state_d = ST_INT_JMP;
            end
            ST_INT_JMP: begin
                ctl.pc_from_hdl = 1'b1;
                state_d = ST_FETCH_ADDR;
            end
            default: state_d = ST_FETCH_ADDR;
        endcase
    end

    // R11
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R6
    exec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_req && !exec_done) |=> exec_req);

    // R6
    exec_quiet_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_req |-> !(mem_rd || mem_wr));

    // R10
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

    // R10
    ack_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_ack) |-> ($past(ie) && $past(irq_req)));

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
    import seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int IND_BIT = 15,
    parameter logic [ADDR_W-1:0] START_ADDR   = '0,
    parameter logic [ADDR_W-1:0] SAVE_ADDR    = '1,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_ctl_t          ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              ie_set,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] ir,
    output logic [ADDR_W-1:0] mar,
    output logic [DATA_W-1:0] mbr,
    output logic              ie,
    output logic              ir_ind
);

    logic [DATA_W-1:0] pc_ext;

    always_comb begin
        pc_ext = '0;
        pc_ext[ADDR_W-1:0] = pc;
    end

    assign ir_ind = ir[IND_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc  <= START_ADDR;
            ir  <= '0;
            mar <= '0;
            mbr <= '0;
            ie  <= 1'b0;
        end else begin
            if (ctl.mar_from_pc)        mar <= pc;
            else if (ctl.mar_from_mbr)  mar <= mbr[ADDR_W-1:0];
            else if (ctl.mar_from_save) mar <= SAVE_ADDR;

            if (ctl.mbr_from_mem)       mbr <= mem_rdata;
            else if (ctl.mbr_from_pc)   mbr <= pc_ext;

            if (ctl.ir_from_mbr)        ir <= mbr;

            if (ctl.pc_from_hdl)        pc <= HANDLER_ADDR;
            else if (ctl.pc_inc)        pc <= pc + 1'b1;

            if (ctl.ie_clr)             ie <= 1'b0;
            else if (ie_set)            ie <= 1'b1;
        end
    end

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_inc |=> (pc == $past(pc) + 1'b1));

    // R9
    pc_handler_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_from_hdl |=> (pc == HANDLER_ADDR));

    // R10
    ie_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ie_clr |=> !ie);

endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
    import seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int IND_BIT = 15,
    parameter logic [ADDR_W-1:0] START_ADDR   = 12'h010,
    parameter logic [ADDR_W-1:0] SAVE_ADDR    = 12'h0F0,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h080
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              exec_req,
    input  logic              exec_done,
    output logic [DATA_W-1:0] instr,
    output logic [ADDR_W-1:0] operand_addr,
    output logic [ADDR_W-1:0] pc_out,
    input  logic              irq_req,
    output logic              irq_ack,
    input  logic              ie_set
);

    seq_ctl_t          ctl;
    logic              ie, ir_ind;
    logic [ADDR_W-1:0] mar;
    logic [DATA_W-1:0] mbr;

    seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_ready (mem_ready),
        .exec_done (exec_done),
        .irq_req   (irq_req),
        .ie        (ie),
        .ir_ind    (ir_ind),
        .ctl       (ctl),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .exec_req  (exec_req),
        .irq_ack   (irq_ack)
    );

    seq_datapath #(
        .DATA_W       (DATA_W),
        .ADDR_W       (ADDR_W),
        .IND_BIT      (IND_BIT),
        .START_ADDR   (START_ADDR),
        .SAVE_ADDR    (SAVE_ADDR),
        .HANDLER_ADDR (HANDLER_ADDR)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .ie_set    (ie_set),
        .pc        (pc_out),
        .ir        (instr),
        .mar       (mar),
        .mbr       (mbr),
        .ie        (ie),
        .ir_ind    (ir_ind)
    );

    assign mem_addr     = mar;
    assign mem_wdata    = mbr;
    assign operand_addr = mbr[ADDR_W-1:0];

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

    // R3
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    // R8
    save_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr == SAVE_ADDR));

endmodule

// File: tb/instr_cycle_seq_bench.sv
module instr_cycle_seq_bench;

    typedef struct {
        bit          wr;
        logic [11:0] a;
        logic [15:0] d;
        string       req;
    } txn_t;

    typedef struct {
        logic [15:0] ir;
        logic [11:0] op;
        logic [11:0] pc;
        string       req;
    } exe_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        exec_req;
    logic        exec_done = 1'b0;
    logic [15:0] instr;
    logic [11:0] operand_addr, pc_out;
    logic        irq_req = 1'b0;
    logic        irq_ack;
    logic        ie_set = 1'b0;

    logic [15:0] mem [0:255];
    txn_t txq[$];
    exe_t exq[$];
    int errors = 0, checks = 0;
    int n_exec = 0, n_ack = 0, n_txn = 0, wcnt = 0, ecnt = 0;
    bit mon_on = 1'b0;

    always #5 clk = ~clk;

    instr_cycle_seq u_instr_cycle_seq (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .exec_req(exec_req), .exec_done(exec_done), .instr(instr),
        .operand_addr(operand_addr), .pc_out(pc_out), .irq_req(irq_req),
        .irq_ack(irq_ack), .ie_set(ie_set)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push_instr(input logic [11:0] pc);
        txn_t t;
        exe_t e;
        logic [15:0] w;
        w = mem[pc[7:0]];
        t.wr = 1'b0; t.a = pc; t.d = 'x; t.req = "R2";
        txq.push_back(t);
        e.ir = w; e.pc = pc + 12'd1;
        if (w[15]) begin
            t.a = w[11:0]; t.req = "R4";
            txq.push_back(t);
            e.op = mem[w[7:0]][11:0]; e.req = "R4";
        end else begin
            e.op = w[11:0]; e.req = "R5";
        end
        exq.push_back(e);
    endtask

    task automatic push_save(input logic [11:0] ret);
        txn_t t;
        t.wr = 1'b1; t.a = 12'h0F0; t.d = {4'h0, ret}; t.req = "R8";
        txq.push_back(t);
    endtask

    // memory model and transaction monitor
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
            wcnt = 0;
        end else if (mem_rd || mem_wr) begin
            if (wcnt >= (n_txn % 3)) begin
                mem_ready = 1'b1;
                n_txn++;
                if (mon_on) begin
                    if (txq.size() == 0) begin
                        check(1'b0, "R7", "unexpected access", {20'h0, mem_addr}, 32'h0);
                    end else begin
                        txn_t t;
                        t = txq.pop_front();
                        check(mem_wr == t.wr, t.req, "direction", mem_wr, t.wr);
                        check(mem_addr == t.a, t.req, "address", mem_addr, t.a);
                        if (t.wr)
                            check(mem_wdata == t.d, t.req, "save data", mem_wdata, t.d);
                    end
                end
                if (mem_wr) mem[mem_addr[7:0]] = mem_wdata;
                else        mem_rdata = mem[mem_addr[7:0]];
            end else begin
                wcnt++;
            end
        end
    end

    // execute model and monitor
    always @(negedge clk) begin
        ie_set = 1'b0;
        if (irq_ack) n_ack++;
        if (exec_done) begin
            exec_done = 1'b0;
            if (n_exec == 3 || n_exec == 6) ie_set = 1'b1;
        end else if (exec_req) begin
            if (ecnt >= 1) begin
                ecnt = 0;
                n_exec++;
                exec_done = 1'b1;
                if (mon_on && exq.size() != 0) begin
                    exe_t e;
                    e = exq.pop_front();
                    check(instr == e.ir, "R2", "instruction", instr, e.ir);
                    check(pc_out == e.pc, "R2", "pc advanced", pc_out, e.pc);
                    check(operand_addr == e.op, e.req, "operand", operand_addr, e.op);
                end
            end else begin
                ecnt++;
            end
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        mem[8'h10] = 16'h0123;
        mem[8'h11] = 16'h8040;
        mem[8'h12] = 16'h0055;
        mem[8'h13] = 16'h0200;
        mem[8'h40] = 16'h0ABC;
        mem[8'h41] = 16'h0DEF;
        mem[8'h80] = 16'h0077;
        mem[8'h81] = 16'h8041;
        mem[8'h82] = 16'h0001;

        // R1: pending request while disabled is not taken (R7)
        push_instr(12'h010);
        push_instr(12'h011);
        push_instr(12'h012);
        push_instr(12'h013);
        push_save(12'h014);       // R8 after ie_set
        push_instr(12'h080);      // R9
        push_instr(12'h081);      // R10 no nested entry
        push_instr(12'h082);
        push_save(12'h083);       // R10 re-enabled
        push_instr(12'h080);

        irq_req = 1'b1;
        repeat (3) @(negedge clk);
        check(pc_out == 12'h010, "R1", "pc in reset", pc_out, 12'h010);
        check(!mem_rd && !mem_wr && !irq_ack, "R1", "idle in reset",
              {mem_rd, mem_wr, irq_ack}, 0);
        mon_on = 1'b1;
        @(posedge clk);
        rst_n <= 1'b1;
        @(negedge clk);
        check(pc_out == 12'h010, "R1", "pc after reset", pc_out, 12'h010);
        check(!mem_rd && !mem_wr && !irq_ack, "R1", "idle after reset",
              {mem_rd, mem_wr, irq_ack}, 0);

        fork
            begin
                wait (n_exec >= 8);
            end
            begin
                repeat (5000) @(negedge clk);
                check(1'b0, "R6", "watchdog expired", n_exec, 8);
            end
        join_any
        disable fork;
        mon_on = 1'b0;
        repeat (4) @(negedge clk);
        check(txq.size() == 0, "R9", "accesses outstanding", txq.size(), 0);
        check(n_ack == 2, "R10", "ack pulses", n_ack, 2);
        check(mem[8'hF0] == 16'h0083, "R8", "saved word", mem[8'hF0], 16'h0083);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule